// File: doc/BRIEF.md
# Sync Activity Monitor and Source Selector

This block watches four sync-related inputs of a video capture front end: horizontal sync, vertical sync, sync-on-green and coast. Each input first passes through a two-flop synchronizer. Over a free-running window of `WIN_LEN` clock cycles the block then decides whether the input toggled and which level it rests at. The resting level is the longer-lasting one, so the pulse polarity is the opposite level.

From the activity results the block chooses which horizontal sync source feeds the clock recovery loop: the dedicated pin or sync-on-green. It also chooses which vertical sync source is used: the dedicated input or the output of the sync separator. A priority bit breaks ties. An override bit makes the choice follow the priority bit regardless of activity. All results are gathered into one status byte that a register read path can sample directly.

Top module: `sync_status_monitor`

## Requirements
- R1: An input that shows at least one rising edge in a full window reports activity 1. An input held steadily high or steadily low for a full window reports 0. The horizontal sync detect is status bit 7, the vertical sync detect is bit 4 and the sync-on-green detect is bit 1.
- R2: Detect and polarity bits change only at window boundaries. A rising edge that arrives in the last cycle of a window counts for that window, so a periodic input with exactly one rising edge per window reports activity continuously.
- R3: With `hs_override` at 0, `hs_src_sel` (0 = horizontal sync pin, 1 = sync-on-green) depends on the detect results. It is 0 when only horizontal sync is active and 1 when only sync-on-green is active. When both or neither are active it equals `hs_prio`.
- R4: With `hs_override` at 1, `hs_src_sel` equals `hs_prio` whatever the detect results are.
- R5: `vs_src_sel` (0 = vertical sync input, 1 = separator output) depends on `vs_override`. With `vs_override` at 0 it is 0 when vertical sync activity is detected and 1 when it is not. With `vs_override` at 1 it equals `vs_prio`.
- R6: A polarity bit is 1 when the input spent strictly less than half of the window high, and 0 otherwise. A steady-high input therefore reports 0 and a steady-low input reports 1. The horizontal sync polarity is status bit 5, the vertical sync polarity is bit 2 and the coast polarity is bit 0.
- R7: `status_byte` bit 6 mirrors `hs_src_sel` and bit 3 mirrors `vs_src_sel`. The remaining bits hold the fields placed by R1 and R6.
- R8: After reset, every detect and polarity bit is 0. `hs_src_sel` equals `hs_prio`. `vs_src_sel` equals `vs_prio` when overridden and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_in | input | 1 | Horizontal sync input |
| vsync_in | input | 1 | Vertical sync input |
| sog_in | input | 1 | Sliced sync-on-green input |
| coast_in | input | 1 | Coast input |
| hs_prio | input | 1 | Horizontal source priority / forced value |
| hs_override | input | 1 | Force horizontal source to `hs_prio` |
| vs_prio | input | 1 | Vertical source forced value |
| vs_override | input | 1 | Force vertical source to `vs_prio` |
| status_byte | output | 8 | Packed detect, polarity and select status |
| hs_src_sel | output | 1 | Selected horizontal sync source |
| vs_src_sel | output | 1 | Selected vertical sync source |

## Verification
The window boundary and a rising edge of a watched input can land in the same cycle. If the edge is dropped, the detect bit flickers to 0 for one window. The bench provokes this collision by driving periodic inputs whose period divides the window, up to one edge per window, and by letting every phase offset occur across random trials. It then samples the status byte at several points spread over a whole window and expects the detect bit to stay 1 throughout. A change of configuration bits in the same cycle as a boundary is also judged, because the select outputs must follow the configuration bits immediately while the detect bits move only at the boundary.

// File: rtl/sync_mon_pkg.sv
package sync_mon_pkg;

  // Horizontal source: 0 = dedicated pin, 1 = sync-on-green
  function automatic logic pick_hs_src(input logic hs_act, input logic sog_act,
                                       input logic prio, input logic force_en);
    logic sel;
    if (force_en) sel = prio;
    else if (hs_act && !sog_act) sel = 1'b0;
    else if (!hs_act && sog_act) sel = 1'b1;
    else sel = prio;
    return sel;
  endfunction

  // Vertical source: 0 = dedicated input, 1 = separator output
  function automatic logic pick_vs_src(input logic vs_act, input logic prio,
                                       input logic force_en);
    return force_en ? prio : !vs_act;
  endfunction

  function automatic logic [7:0] pack_status(
      input logic hs_det, input logic hs_sel, input logic hs_pol,
      input logic vs_det, input logic vs_sel, input logic vs_pol,
      input logic sog_det, input logic coast_pol);
    return {hs_det, hs_sel, hs_pol, vs_det, vs_sel, vs_pol, sog_det, coast_pol};
  endfunction

endpackage

// File: rtl/sync_cdc2.sv
module sync_cdc2 #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] q_out
);
  logic [N-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_out  <= '0;
    end else begin
      meta_q <= d_in;
      q_out  <= meta_q;
    end
  end
endmodule

// File: rtl/sync_win_timer.sv
module sync_win_timer #(
  parameter int WIN_LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_end
);
  localparam int CNT_W = $clog2(WIN_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  assign win_end = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (win_end) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R2
  win_end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> !win_end);
endmodule

// File: rtl/sync_activity.sv
module sync_activity (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic win_end,
  output logic active
);
  logic prev_q, seen_q, rise;

  assign rise = level && !prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
      active <= 1'b0;
    end else begin
      prev_q <= level;
      if (win_end) begin
        active <= seen_q || rise;
        seen_q <= 1'b0;
      end else if (rise) begin
        seen_q <= 1'b1;
      end
    end
  end

  // R2
  det_moves_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(active));

  // R1
  seen_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> !seen_q);

  // R1
  boundary_edge_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && rise) |=> active);
endmodule

// File: rtl/sync_polarity.sv
module sync_polarity #(
  parameter int WIN_LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic win_end,
  output logic pol_high
);
  localparam int HC_W = $clog2(WIN_LEN + 1);
  localparam logic [HC_W:0] WIN_REF = (HC_W + 1)'(WIN_LEN);

  logic [HC_W-1:0] high_q;
  logic [HC_W-1:0] high_total;
  logic            short_high;

  assign high_total = high_q + HC_W'(level);
  // high level is the minority share of the window
  assign short_high = ({high_total, 1'b0} < WIN_REF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_q   <= '0;
      pol_high <= 1'b0;
    end else if (win_end) begin
      high_q   <= '0;
      pol_high <= short_high;
    end else begin
      high_q   <= high_total;
    end
  end

  // R2
  pol_moves_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(pol_high));

  // R6
  high_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    high_q < HC_W'(WIN_LEN));
endmodule

// File: rtl/sync_status_monitor.sv
module sync_status_monitor
  import sync_mon_pkg::*;
#(
  parameter int WIN_LEN = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync_in,
  input  logic       vsync_in,
  input  logic       sog_in,
  input  logic       coast_in,
  input  logic       hs_prio,
  input  logic       hs_override,
  input  logic       vs_prio,
  input  logic       vs_override,
  output logic [7:0] status_byte,
  output logic       hs_src_sel,
  output logic       vs_src_sel
);
  localparam int NUM_IN  = 4;
  localparam int NUM_ACT = 3;  // hsync, vsync, sog
  localparam int NUM_POL = 3;  // hsync, vsync, coast

  logic [NUM_IN-1:0]  raw_in, syncd;
  logic [NUM_ACT-1:0] act_src, act_det;
  logic [NUM_POL-1:0] pol_src, pol_det;
  logic               win_end;

  assign raw_in = {coast_in, sog_in, vsync_in, hsync_in};

  sync_cdc2 #(.N(NUM_IN)) u_cdc (
    .clk(clk), .rst_n(rst_n), .d_in(raw_in), .q_out(syncd)
  );

  sync_win_timer #(.WIN_LEN(WIN_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .win_end(win_end)
  );

  assign act_src = {syncd[2], syncd[1], syncd[0]};
  assign pol_src = {syncd[3], syncd[1], syncd[0]};

  genvar g;
  generate
    for (g = 0; g < NUM_ACT; g++) begin : g_act
      sync_activity u_act (
        .clk(clk), .rst_n(rst_n), .level(act_src[g]),
        .win_end(win_end), .active(act_det[g])
      );
    end
    for (g = 0; g < NUM_POL; g++) begin : g_pol
      sync_polarity #(.WIN_LEN(WIN_LEN)) u_pol (
        .clk(clk), .rst_n(rst_n), .level(pol_src[g]),
        .win_end(win_end), .pol_high(pol_det[g])
      );
    end
  endgenerate

  assign hs_src_sel = pick_hs_src(act_det[0], act_det[2], hs_prio, hs_override);
  assign vs_src_sel = pick_vs_src(act_det[1], vs_prio, vs_override);

  assign status_byte = pack_status(act_det[0], hs_src_sel, pol_det[0],
                                   act_det[1], vs_src_sel, pol_det[1],
                                   act_det[2], pol_det[2]);

  // R3
  hs_only_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_override && act_det[0] && !act_det[2]) |-> !hs_src_sel);

  // R3
  hs_only_sog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_override && !act_det[0] && act_det[2]) |-> hs_src_sel);

  // R4
  hs_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_override |-> (hs_src_sel == hs_prio));

  // R5
  vs_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_override |-> (vs_src_sel != act_det[1]));

  // R7
  status_sel_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[6] == hs_src_sel) && (status_byte[3] == vs_src_sel));
endmodule

// File: tb/test_sync_status_monitor.sv
module test_sync_status_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_in = 0, vsync_in = 0, sog_in = 0, coast_in = 0;
  logic hs_prio = 0, hs_override = 0, vs_prio = 0, vs_override = 0;
  logic [7:0] status_byte;
  logic hs_src_sel, vs_src_sel;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // channel pattern: per==0 means steady at level hi; else high for hi of per cycles
  int per_q[4];
  int hi_q[4];
  int ph_q[4];
  int tick = 0;

  sync_status_monitor #(.WIN_LEN(WIN)) i_sync_status_monitor (
    .clk(clk), .rst_n(rst_n),
    .hsync_in(hsync_in), .vsync_in(vsync_in), .sog_in(sog_in), .coast_in(coast_in),
    .hs_prio(hs_prio), .hs_override(hs_override),
    .vs_prio(vs_prio), .vs_override(vs_override),
    .status_byte(status_byte), .hs_src_sel(hs_src_sel), .vs_src_sel(vs_src_sel)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic lvl_of(int ch, int t);
    if (per_q[ch] == 0) return logic'(hi_q[ch] != 0);
    return logic'(((t + ph_q[ch]) % per_q[ch]) < hi_q[ch]);
  endfunction

  function automatic logic exp_det(int ch);
    return logic'(per_q[ch] != 0);
  endfunction

  function automatic logic exp_pol(int ch);
    if (per_q[ch] == 0) return logic'(hi_q[ch] == 0);
    return logic'(2 * hi_q[ch] < per_q[ch]);
  endfunction

  function automatic logic exp_hs_sel(logic dh, logic ds);
    if (hs_override) return hs_prio;
    if (dh != ds) return ds;
    return hs_prio;
  endfunction

  function automatic logic exp_vs_sel(logic dv);
    return vs_override ? vs_prio : !dv;
  endfunction

  function automatic logic [7:0] exp_status();
    logic dh, dv, ds;
    dh = exp_det(0); dv = exp_det(1); ds = exp_det(2);
    return {dh, exp_hs_sel(dh, ds), exp_pol(0), dv, exp_vs_sel(dv), exp_pol(1),
            ds, exp_pol(3)};
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // input driver
  initial begin
    forever begin
      @(negedge clk);
      tick++;
      hsync_in = lvl_of(0, tick);
      vsync_in = lvl_of(1, tick);
      sog_in   = lvl_of(2, tick);
      coast_in = lvl_of(3, tick);
    end
  end

  task automatic set_ch(int ch, int per, int hi, int ph);
    per_q[ch] = per; hi_q[ch] = hi; ph_q[ch] = ph;
  endtask

  task automatic rand_ch(int ch);
    int pick;
    int per;
    pick = int'($urandom_range(0, 6));
    if (pick == 0) set_ch(ch, 0, 0, 0);
    else if (pick == 1) set_ch(ch, 0, 1, 0);
    else begin
      per = 4 << (pick - 2);            // 4,8,16,32,64
      set_ch(ch, per, int'($urandom_range(1, per - 1)), int'($urandom_range(0, per - 1)));
    end
  endtask

  task automatic settle_and_check(string tag);
    repeat (3 * WIN + 4) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      #1;
      // R1 R6 R7: whole byte and select outputs
      chk({tag, " R7 status"}, status_byte, exp_status());
      chk({tag, " R1 hs detect"}, status_byte[7], exp_det(0));
      chk({tag, " R2 sog detect steady"}, status_byte[1], exp_det(2));
      chk({tag, " R6 coast pol"}, status_byte[0], exp_pol(3));
      chk({tag, " R3 hs sel"}, hs_src_sel, exp_hs_sel(exp_det(0), exp_det(2)));
      chk({tag, " R5 vs sel"}, vs_src_sel, exp_vs_sel(exp_det(1)));
      repeat (9) @(negedge clk);
    end
  endtask

  task automatic cfg_sweep(string tag);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      hs_prio = c[0]; hs_override = c[1]; vs_prio = c[2]; vs_override = c[3];
      #1;
      if (hs_override) chk({tag, " R4 hs forced"}, hs_src_sel, hs_prio);
      else chk({tag, " R3 hs sel"}, hs_src_sel, exp_hs_sel(exp_det(0), exp_det(2)));
      chk({tag, " R5 vs sel"}, vs_src_sel, exp_vs_sel(exp_det(1)));
      chk({tag, " R7 byte"}, status_byte, exp_status());
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    for (int ch = 0; ch < 4; ch++) set_ch(ch, 0, 0, 0);
    hs_prio = 1; vs_prio = 0; vs_override = 0; hs_override = 0;
    repeat (3) @(negedge clk);
    #1;
    // R8 reset state
    chk("R8 status under reset", status_byte, 8'b0100_1000);
    chk("R8 hs sel", hs_src_sel, 1);
    chk("R8 vs sel", vs_src_sel, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R8 status after release", status_byte, 8'b0100_1000);

    // directed: only hsync active, then only sog, then both (R3), override (R4)
    set_ch(0, 16, 4, 0); settle_and_check("hs only");
    set_ch(0, 0, 1, 0); set_ch(2, 8, 6, 3); settle_and_check("sog only");
    set_ch(0, 64, 1, 17); settle_and_check("both, one edge per window R2");
    cfg_sweep("both");
    set_ch(0, 0, 0, 0); set_ch(2, 0, 1, 0); set_ch(1, 0, 0, 0); set_ch(3, 0, 1, 0);
    settle_and_check("all steady R1");
    cfg_sweep("neither");

    // random trials
    for (int it = 0; it < 24; it++) begin
      for (int ch = 0; ch < 4; ch++) rand_ch(ch);
      hs_prio = logic'($urandom_range(0, 1));
      hs_override = logic'($urandom_range(0, 1));
      vs_prio = logic'($urandom_range(0, 1));
      vs_override = logic'($urandom_range(0, 1));
      settle_and_check("random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule